// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit resolves data hazards for an in-order 32-bit integer pipeline with five stages (fetch, decode, execute, memory, writeback). Each cycle it takes the instruction word sitting in decode together with that instruction's format flag, register-write enable and memory-read flag. It carries the register tags of that instruction down a private tag pipeline that mirrors the execute, memory and writeback pipeline registers. From those tags it produces one bypass select code for each of the two execute-stage operand multiplexers.

A load cannot hand its data to the very next instruction, because the data only exists at the end of the memory stage. When the instruction in decode reads the register that a load in execute will write, the unit raises a stall, which freezes the PC and the fetch/decode register, and a bubble, which turns the next execute slot into a no-op. The register file is assumed to write early in the cycle and read late. For that reason nothing is bypassed from writeback into decode.

Top module: `hazard_unit`

## Requirements
- R1: While reset is held (synchronous, active low), and with all-zero decode inputs after it, both select codes read 2'b00 and stall and bubble are low.
- R2: An instruction that reads, as its first source (bits 25:21) or second source (bits 20:16), the register written by the instruction directly ahead of it gets select 2'b10 (execute/memory result) on that operand while it is in execute.
- R3: A source that matches the destination of the instruction two ahead gets select 2'b01 (memory/writeback result), and a source that matches the destination of the instruction three ahead gets 2'b00.
- R4: When both later stages write the register a source reads, that operand's select is 2'b10.
- R5: A destination of register 0 never causes a bypass or a stall.
- R6: A producer whose register-write enable is low never causes a bypass or a stall.
- R7: The destination is bits 15:11 when the format flag is 1 (register format) and bits 20:16 when it is 0 (immediate format). The other field is never treated as a destination.
- R8: A load (memory-read and register-write high) in execute whose destination is read by the decode instruction raises stall and bubble in that same cycle, for exactly one cycle. The consumer then reaches execute with select 2'b01.
- R9: A load followed by an instruction that does not read the load's destination causes no stall.
- R10: A load with one unrelated instruction between it and its consumer causes no stall, and the consumer gets select 2'b01.
- R11: The bubble carries no register write, so it never produces a bypass for the instructions behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_instr | input | 32 | Instruction word in decode |
| id_reg_fmt | input | 1 | 1: register format (destination in bits 15:11); 0: immediate format (destination in bits 20:16) |
| id_reg_write | input | 1 | Decode instruction writes a register |
| id_mem_read | input | 1 | Decode instruction is a load |
| fwd_a | output | 2 | Select for the first execute operand: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b | output | 2 | Select for the second execute operand, same encoding |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The main sweep places a producer one, two or three instructions ahead of a consumer. It varies the producer between an ALU operation and a load, its destination among register 0, a mid register and register 31, its format, its write enable, and which source field the consumer reads. Comparing distances separates the two bypass paths from the plain register-file path. Comparing loads against ALU producers at distance one isolates the single stall, and the select that follows the stall shows that the bubble writes nothing. Separate patterns cover both later stages writing the same register, a load followed by an unrelated reader, and a decoy value in the non-destination field.

// File: rtl/hz_pkg.sv
// Shared types for the hazard unit: register index, bypass select code and
// the per-stage register tag. Assumes 32 architectural registers.
package hz_pkg;
    localparam int unsigned RIDX_W = 5;

    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        FWD_RF = 2'b00,
        FWD_MW = 2'b01,
        FWD_XM = 2'b10
    } fwd_sel_t;

    typedef struct packed {
        ridx_t rs;
        ridx_t rt;
        ridx_t dst;
        logic  we;
        logic  mr;
    } stage_tag_t;

    localparam stage_tag_t TAG_IDLE = '0;
endpackage

// File: rtl/hz_field_split.sv
// Splits a decode-stage instruction into its register tag. Sources come
// from fixed fields; the destination is picked by the format flag.
// Assumes both source fields sit at the same place in every format.
module hz_field_split
    import hz_pkg::*;
#(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned RS_LSB  = 21,
    parameter int unsigned RT_LSB  = 16,
    parameter int unsigned RD_LSB  = 11
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               reg_fmt,
    input  logic               reg_write,
    input  logic               mem_read,
    output stage_tag_t         tag
);
    localparam int unsigned TOP_USED = RS_LSB + RIDX_W;

    logic unused_bits;
    assign unused_bits = ^{instr[INSTR_W-1:TOP_USED], instr[RD_LSB-1:0]};

    // Build the tag: fixed source fields, format-dependent destination.
    always_comb begin
        tag.rs  = instr[RS_LSB +: RIDX_W];
        tag.rt  = instr[RT_LSB +: RIDX_W];
        tag.dst = reg_fmt ? instr[RD_LSB +: RIDX_W] : instr[RT_LSB +: RIDX_W];
        tag.we  = reg_write;
        tag.mr  = mem_read;
    end
endmodule

// File: rtl/hz_tag_pipe.sv
// Mirror of the decode/execute, execute/memory and memory/writeback
// pipeline registers, holding only register tags. A bubble loads an idle
// tag (no write, no load) into the execute slot.
module hz_tag_pipe
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stage_tag_t id_tag,
    input  logic       bubble,
    output stage_tag_t ex_tag,
    output stage_tag_t xm_tag,
    output stage_tag_t mw_tag
);
    // Advance the tags one stage per cycle, injecting an idle tag on bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_tag <= TAG_IDLE;
            xm_tag <= TAG_IDLE;
            mw_tag <= TAG_IDLE;
        end else begin
            ex_tag <= bubble ? TAG_IDLE : id_tag;
            xm_tag <= ex_tag;
            mw_tag <= xm_tag;
        end
    end

    // R11: the slot behind a bubble never claims a register write.
    a_r11_bubble_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (!ex_tag.we && !ex_tag.mr));
endmodule

// File: rtl/hz_fwd_pick.sv
// Bypass select generation, one copy per execute operand. The nearer stage
// (execute/memory) wins over memory/writeback; register 0 and non-writing
// producers never match. Assumes write-before-read in the register file.
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ridx_t      src [NUM_SRC],
    input  stage_tag_t xm_tag,
    input  stage_tag_t mw_tag,
    output fwd_sel_t   sel [NUM_SRC]
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        logic xm_hit, mw_hit;

        // Match this operand against each later stage's destination.
        always_comb begin
            xm_hit = xm_tag.we && (xm_tag.dst != '0) && (xm_tag.dst == src[g]);
            mw_hit = mw_tag.we && (mw_tag.dst != '0) && (mw_tag.dst == src[g]);
        end

        // Priority pick: nearest producer first.
        always_comb begin
            if (xm_hit)      sel[g] = FWD_XM;
            else if (mw_hit) sel[g] = FWD_MW;
            else             sel[g] = FWD_RF;
        end

        // R5: a bypass never serves register 0.
        a_r5_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[g] != FWD_RF) |-> (src[g] != '0));
    end
endmodule

// File: rtl/hz_load_use.sv
// Load-use detector: a load in execute whose destination is read by the
// decode instruction forces one stall. Both source fields are compared
// before the decode instruction's format is known.
module hz_load_use
    import hz_pkg::*;
(
    input  stage_tag_t ex_tag,
    input  ridx_t      id_rs,
    input  ridx_t      id_rt,
    output logic       stall
);
    // Raise stall when a live load feeds the decode instruction.
    always_comb begin
        stall = ex_tag.mr && ex_tag.we && (ex_tag.dst != '0) &&
                ((ex_tag.dst == id_rs) || (ex_tag.dst == id_rt));
    end
endmodule

// File: rtl/hazard_unit.sv
// Top of the hazard unit: splits the decode instruction, tracks register
// tags through execute, memory and writeback, generates operand bypass
// selects and the load-use stall/bubble. Assumes the datapath freezes PC
// and fetch/decode on stall and honours bubble in the same cycle.
module hazard_unit
    import hz_pkg::*;
#(
    parameter int unsigned INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] id_instr,
    input  logic               id_reg_fmt,
    input  logic               id_reg_write,
    input  logic               id_mem_read,
    output logic [1:0]         fwd_a,
    output logic [1:0]         fwd_b,
    output logic               stall,
    output logic               bubble
);
    localparam int unsigned NUM_SRC = 2;

    stage_tag_t id_tag, ex_tag, xm_tag, mw_tag;
    ridx_t      ex_src [NUM_SRC];
    fwd_sel_t   sel    [NUM_SRC];
    logic       lu_stall;

    hz_field_split #(.INSTR_W(INSTR_W)) u_split (
        .instr     (id_instr),
        .reg_fmt   (id_reg_fmt),
        .reg_write (id_reg_write),
        .mem_read  (id_mem_read),
        .tag       (id_tag)
    );

    hz_tag_pipe u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .id_tag (id_tag),
        .bubble (bubble),
        .ex_tag (ex_tag),
        .xm_tag (xm_tag),
        .mw_tag (mw_tag)
    );

    // Present the execute instruction's two sources to the bypass pickers.
    always_comb begin
        ex_src[0] = ex_tag.rs;
        ex_src[1] = ex_tag.rt;
    end

    hz_fwd_pick #(.NUM_SRC(NUM_SRC)) u_fwd (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (ex_src),
        .xm_tag (xm_tag),
        .mw_tag (mw_tag),
        .sel    (sel)
    );

    hz_load_use u_lu (
        .ex_tag (ex_tag),
        .id_rs  (id_tag.rs),
        .id_rt  (id_tag.rt),
        .stall  (lu_stall)
    );

    // Drive the outputs; the bubble accompanies every stall.
    always_comb begin
        fwd_a  = sel[0];
        fwd_b  = sel[1];
        stall  = lu_stall;
        bubble = lu_stall;
    end

    logic unused_tags;
    assign unused_tags = ^{xm_tag.rs, xm_tag.rt, xm_tag.mr, mw_tag.rs, mw_tag.rt, mw_tag.mr};

    // R8: a stall never lasts two cycles in a row.
    a_r8_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R8: a load in the memory stage is never the bypass source of execute.
    a_r8_no_load_via_xm: assert property (@(posedge clk) disable iff (!rst_n)
        xm_tag.mr |-> (fwd_a != FWD_XM && fwd_b != FWD_XM));

    // R3: the memory/writeback path is chosen only for a writing producer.
    a_r3_mw_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == FWD_MW || fwd_b == FWD_MW) |-> mw_tag.we);

    // R2: the execute/memory path is chosen only for a writing producer.
    a_r2_xm_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == FWD_XM || fwd_b == FWD_XM) |-> xm_tag.we);
endmodule

// File: tb/tb_hazard_unit.sv
`timescale 1ns/1ps
module tb_hazard_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] id_instr = '0;
    logic        id_reg_fmt = 1'b0;
    logic        id_reg_write = 1'b0;
    logic        id_mem_read = 1'b0;
    logic [1:0]  fwd_a, fwd_b;
    logic        stall, bubble;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hazard_unit dut (
        .clk(clk), .rst_n(rst_n), .id_instr(id_instr), .id_reg_fmt(id_reg_fmt),
        .id_reg_write(id_reg_write), .id_mem_read(id_mem_read),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble)
    );

    function automatic logic [31:0] enc(input int rs, input int rt, input int rd);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 11'd0};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one decode-stage instruction at the falling edge, sample 1 ns later.
    task automatic issue(input int rs, input int rt, input int rd,
                         input bit fmt, input bit we, input bit mr);
        @(negedge clk);
        id_instr = enc(rs, rt, rd);
        id_reg_fmt = fmt;
        id_reg_write = we;
        id_mem_read = mr;
        #1;
    endtask

    task automatic nop();
        issue(0, 0, 0, 1'b1, 1'b0, 1'b0);
    endtask

    // Scenario: producer, d-1 nops, consumer, then the consumer's execute cycle.
    task automatic scenario(input int p, input bit ld, input bit we, input bit fmt,
                            input int d, input bit use_rt);
        bit    exp_stall;
        int    eff, exp_sel;
        string tag;
        exp_stall = ld && we && (p != 0) && (d == 1);
        if (p == 0)               tag = "R5";
        else if (!we)             tag = "R6";
        else if (ld && d == 1)    tag = "R8/R11";
        else if (ld && d == 2)    tag = "R10";
        else if (d == 1)          tag = "R2/R7";
        else                      tag = "R3/R7";
        if (fmt) issue(7, 20, p, 1'b1, we, ld);
        else     issue(7, p, 20, 1'b0, we, ld);
        for (int k = 1; k < d; k++) nop();
        if (use_rt) issue(9, p, 0, 1'b1, 1'b0, 1'b0);
        else        issue(p, 9, 0, 1'b1, 1'b0, 1'b0);
        chk({tag, " stall"}, stall, exp_stall);
        chk({tag, " bubble"}, bubble, exp_stall);
        if (exp_stall) begin
            if (use_rt) issue(9, p, 0, 1'b1, 1'b0, 1'b0);
            else        issue(p, 9, 0, 1'b1, 1'b0, 1'b0);
            chk("R8 stall once", stall, 0);
        end
        nop();
        eff = d + (exp_stall ? 1 : 0);
        if (!we || p == 0)  exp_sel = 0;
        else if (eff == 1)  exp_sel = 2;
        else if (eff == 2)  exp_sel = 1;
        else                exp_sel = 0;
        chk({tag, " fwd on reader"}, use_rt ? fwd_b : fwd_a, exp_sel);
        chk({tag, " fwd on other"}, use_rt ? fwd_a : fwd_b, 0);
        nop(); nop(); nop();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset fwd_a", fwd_a, 0);
        chk("R1 reset fwd_b", fwd_b, 0);
        chk("R1 reset stall", stall, 0);
        rst_n = 1'b1;
        nop();
        chk("R1 idle stall", stall, 0);
        nop(); nop();
        chk("R1 idle fwd", {fwd_a, fwd_b}, 0);

        // Near-exhaustive sweep of producer/consumer pairings.
        for (int pi = 0; pi < 3; pi++)
            for (int ld = 0; ld < 2; ld++)
                for (int we = 0; we < 2; we++)
                    for (int fmt = 0; fmt < 2; fmt++)
                        for (int d = 1; d <= 3; d++)
                            for (int u = 0; u < 2; u++)
                                scenario(pi == 0 ? 0 : (pi == 1 ? 5 : 31),
                                         ld[0], we[0], fmt[0], d, u[0]);

        // R4: both later stages write register 9; nearer one wins.
        issue(0, 0, 9, 1'b1, 1'b1, 1'b0);
        issue(0, 0, 9, 1'b1, 1'b1, 1'b0);
        issue(9, 9, 0, 1'b1, 1'b0, 1'b0);
        nop();
        chk("R4 priority fwd_a", fwd_a, 2);
        chk("R4 priority fwd_b", fwd_b, 2);
        nop(); nop(); nop();

        // R9: load of r5 followed by a reader of r7 and r8 only.
        issue(0, 5, 0, 1'b0, 1'b1, 1'b1);
        issue(7, 8, 0, 1'b1, 1'b0, 1'b0);
        chk("R9 independent stall", stall, 0);
        nop();
        chk("R9 independent fwd", {fwd_a, fwd_b}, 0);
        nop(); nop(); nop();

        // R7: decoy in the non-destination field is not a destination.
        issue(0, 12, 13, 1'b1, 1'b1, 1'b0);
        issue(12, 0, 0, 1'b1, 1'b0, 1'b0);
        nop();
        chk("R7 rt not dest in reg format", fwd_a, 0);
        nop(); nop(); nop();
        issue(0, 12, 13, 1'b0, 1'b1, 1'b1);
        issue(13, 0, 0, 1'b1, 1'b0, 1'b0);
        chk("R7 rd not dest in imm format stall", stall, 0);
        nop();
        chk("R7 rd not dest in imm format fwd", fwd_a, 0);
        nop(); nop(); nop();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule